// File: doc/BRIEF.md
# Isochronous OUT Ping-Pong Packet Buffer

This block is the receive-side store for a single isochronous OUT endpoint of a USB device controller. Bytes arriving from the serial interface engine are written into one of two 128-byte packet slots (256 bytes in all). An end-of-packet strobe closes the slot being filled and records its byte count. The next packet then goes into the other slot. A processor or DMA engine drains closed packets one byte at a time through a single 32-bit data word. Packets come out in the order they arrived.

While at least one closed packet is unread, the block raises an interrupt request and a DMA request. When neither slot is free, it tells the host-facing logic to answer the next OUT token with a NAK. That NAK holds until a whole slot has been drained. Two sticky flags report bytes lost to an over-long packet and pops issued against an empty buffer.

Both data paths are valid/ready. On the write side, `wr_ready` is high while a free slot is being filled. The serial engine cannot stall, so a byte or end-of-packet offered while `wr_ready` is low is discarded rather than held. On the read side, `rd_valid` shows that a closed packet sits at the head. A byte is consumed on each clock edge where `rd_valid` and `rd_ready` are both high. The consumer may hold `rd_ready` low for as long as it likes.

Top module: `iso_out_pingpong`

## Requirements
- R1: After reset, `rd_data` is 0, `rd_valid`, `irq`, `dma_req`, `out_nak`, `ovf_flag` and `udf_flag` are 0, and `wr_ready` is 1.
- R2: A byte is stored when `wr_valid` and `wr_ready` are high at a clock edge. A `wr_eop` accepted at an edge, alone or together with the final byte, closes the packet, and the packet is readable from the following cycle. A `wr_eop` with no byte stored in the current slot closes nothing.
- R3: `irq` and `dma_req` are high exactly while at least one closed packet still has unread bytes.
- R4: `rd_data[7:0]` shows the head byte of the packet being read, `rd_data[31:8]` is always 0, and `rd_valid` is high while a closed packet is at the head. An edge with `rd_valid` and `rd_ready` high consumes one byte.
- R5: Packets are read in arrival order. A slot becomes free in the cycle after its last recorded byte is popped, and reading continues with the other slot.
- R6: `out_nak` is high, and `wr_ready` low, when both slots hold closed packets. Bytes and end-of-packet strobes offered during that time are dropped.
- R7: Once raised, `out_nak` stays high while the head packet is only partly drained. It falls only in the cycle after the final byte of a slot is popped.
- R8: Bytes beyond 128 in one packet are dropped and set `ovf_flag`, which stays set until reset. The packet closes holding its first 128 bytes.
- R9: A pop request (`rd_ready` high) while `rd_valid` is low sets `udf_flag`, which stays set until reset. `rd_data` keeps the last value shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Byte present on `wr_data` |
| wr_ready | output | 1 | A free slot is being filled |
| wr_data | input | 8 | Received byte |
| wr_eop | input | 1 | End of the current packet |
| rd_valid | output | 1 | A closed packet is at the head |
| rd_ready | input | 1 | Pop request from processor or DMA |
| rd_data | output | 32 | Head byte in bits 7:0, upper bits zero |
| out_nak | output | 1 | Answer the next OUT token with NAK |
| irq | output | 1 | Completed packet waiting (interrupt) |
| dma_req | output | 1 | Completed packet waiting (DMA request) |
| ovf_flag | output | 1 | Sticky: bytes dropped from an over-long packet |
| udf_flag | output | 1 | Sticky: pop issued on an empty buffer |

## Verification
The assertions assume that inputs change only between clock edges and are free of X after reset. They also assume that `wr_eop` is a single-cycle strobe per packet, so that no property has to reason about an end-of-packet held high across cycles. The stimulus drives every input shortly after a rising edge and clears the strobes after one cycle. Pops and writes against a full or empty buffer are issued on purpose, so that the drop, NAK and underflow rules are exercised rather than avoided.

// File: rtl/iso_out_pkg.sv
package iso_out_pkg;
  localparam int unsigned NUM_SLOTS = 2;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WORD_W    = 32;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/iso_out_store.sv
module iso_out_store #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  iso_out_pkg::byte_t wdata,
  input  logic [AW-1:0]      raddr,
  output iso_out_pkg::byte_t rdata
);
  iso_out_pkg::byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/iso_out_fill.sv
module iso_out_fill #(
  parameter int unsigned SLOT_BYTES = 128,
  localparam int unsigned IDX_W     = $clog2(SLOT_BYTES),
  localparam int unsigned CNT_W     = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  iso_out_pkg::byte_t wr_data,
  input  logic               wr_eop,
  input  logic               slot_free,
  output logic               wr_ready,
  output logic               mem_we,
  output logic [IDX_W:0]     mem_waddr,
  output iso_out_pkg::byte_t mem_wdata,
  output logic               close,
  output logic               close_slot,
  output logic [CNT_W-1:0]   close_cnt,
  output logic               ovf_flag
);
  logic             wr_slot;
  logic [CNT_W-1:0] fcnt;
  logic             take, room, store, drop_long;

  always_comb begin
    wr_ready  = slot_free;
    take      = wr_valid & slot_free;
    room      = (fcnt < CNT_W'(SLOT_BYTES));
    store     = take & room;
    drop_long = take & ~room;
    close_cnt = fcnt + CNT_W'(store);
    close     = slot_free & wr_eop & (close_cnt != '0);
    mem_we    = store;
    mem_waddr = {wr_slot, fcnt[IDX_W-1:0]};
    mem_wdata = wr_data;
  end

  assign close_slot = wr_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot  <= 1'b0;
      fcnt     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (close) begin
        fcnt    <= '0;
        wr_slot <= ~wr_slot;
      end else if (store) begin
        fcnt <= fcnt + 1'b1;
      end
      if (drop_long) ovf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/iso_out_drain.sv
module iso_out_drain #(
  parameter int unsigned SLOT_BYTES = 128,
  localparam int unsigned IDX_W     = $clog2(SLOT_BYTES),
  localparam int unsigned CNT_W     = IDX_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [iso_out_pkg::NUM_SLOTS-1:0] slot_full,
  input  logic [iso_out_pkg::NUM_SLOTS-1:0][CNT_W-1:0] slot_cnt,
  input  iso_out_pkg::byte_t               mem_rdata,
  input  logic                             rd_ready,
  output logic                             rd_valid,
  output logic [iso_out_pkg::WORD_W-1:0]   rd_data,
  output logic [IDX_W:0]                   mem_raddr,
  output logic                             release_o,
  output logic                             rd_slot,
  output logic                             udf_flag
);
  logic [IDX_W-1:0]   ridx;
  logic [CNT_W-1:0]   cur_cnt;
  iso_out_pkg::byte_t last_q;
  logic               pop, at_end;

  always_comb begin
    rd_valid  = slot_full[rd_slot];
    cur_cnt   = slot_cnt[rd_slot];
    pop       = rd_valid & rd_ready;
    at_end    = ((CNT_W'(ridx) + 1'b1) == cur_cnt);
    release_o = pop & at_end;
    mem_raddr = {rd_slot, ridx};
    rd_data   = {{(iso_out_pkg::WORD_W-iso_out_pkg::BYTE_W){1'b0}},
                 (rd_valid ? mem_rdata : last_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_slot  <= 1'b0;
      ridx     <= '0;
      last_q   <= '0;
      udf_flag <= 1'b0;
    end else begin
      if (pop) begin
        last_q <= mem_rdata;
        if (at_end) begin
          ridx    <= '0;
          rd_slot <= ~rd_slot;
        end else begin
          ridx <= ridx + 1'b1;
        end
      end
      if (rd_ready && !rd_valid) udf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/iso_out_pingpong.sv
module iso_out_pingpong #(
  parameter int unsigned TOTAL_BYTES = 256,
  localparam int unsigned NSLOT      = iso_out_pkg::NUM_SLOTS,
  localparam int unsigned SLOT_BYTES = TOTAL_BYTES / NSLOT,
  localparam int unsigned IDX_W      = $clog2(SLOT_BYTES),
  localparam int unsigned CNT_W      = IDX_W + 1,
  localparam int unsigned AW         = $clog2(TOTAL_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_data,
  input  logic        wr_eop,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_data,
  output logic        out_nak,
  output logic        irq,
  output logic        dma_req,
  output logic        ovf_flag,
  output logic        udf_flag
);
  logic [NSLOT-1:0]            slot_full;
  logic [NSLOT-1:0][CNT_W-1:0] slot_cnt;
  logic                        close, close_slot, release_s, rd_slot;
  logic [CNT_W-1:0]            close_cnt;
  logic                        mem_we;
  logic [AW-1:0]               mem_waddr, mem_raddr;
  iso_out_pkg::byte_t          mem_wdata, mem_rdata;
  logic                        wr_slot_free;

  iso_out_fill #(.SLOT_BYTES(SLOT_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_eop(wr_eop),
    .slot_free(wr_slot_free), .wr_ready(wr_ready),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .close(close), .close_slot(close_slot), .close_cnt(close_cnt),
    .ovf_flag(ovf_flag)
  );

  iso_out_drain #(.SLOT_BYTES(SLOT_BYTES)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .slot_full(slot_full), .slot_cnt(slot_cnt), .mem_rdata(mem_rdata),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_raddr(mem_raddr), .release_o(release_s), .rd_slot(rd_slot),
    .udf_flag(udf_flag)
  );

  iso_out_store #(.DEPTH(TOTAL_BYTES)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_full[s] <= 1'b0;
        slot_cnt[s]  <= '0;
      end else if (close && (close_slot == 1'(s))) begin
        slot_full[s] <= 1'b1;
        slot_cnt[s]  <= close_cnt;
      end else if (release_s && (rd_slot == 1'(s))) begin
        slot_full[s] <= 1'b0;
      end
    end
  end

  // Writer owns the slot its pointer names; that slot is free unless full.
  assign wr_slot_free = ~slot_full[close_slot];
  assign out_nak      = &slot_full;
  assign irq          = |slot_full;
  assign dma_req      = |slot_full;
endmodule

// File: rtl/iso_out_pingpong_chk.sv
module iso_out_pingpong_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        wr_eop,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_data,
  input logic        out_nak,
  input logic        irq,
  input logic        dma_req,
  input logic        ovf_flag,
  input logic        udf_flag
);
  // R3, R5: a waiting packet is always the one at the read head
  assert_irq_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == rd_valid) && (dma_req == irq));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:8] == 24'd0);

  assert_no_spontaneous_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !(wr_valid && wr_ready) && !wr_eop) |=> !rd_valid);

  assert_nak_has_packet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_nak |-> (rd_valid && !wr_ready));

  assert_nak_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_nak && !rd_ready) |=> out_nak);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    udf_flag |=> udf_flag);

  assert_udf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid) |=> (rd_valid || $stable(rd_data)));
endmodule

bind iso_out_pingpong iso_out_pingpong_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_eop(wr_eop), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .out_nak(out_nak), .irq(irq), .dma_req(dma_req),
  .ovf_flag(ovf_flag), .udf_flag(udf_flag)
);

// File: tb/iso_out_pingpong_bench.sv
`timescale 1ns/1ps
module iso_out_pingpong_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_eop = 1'b0, rd_ready = 1'b0;
  logic [7:0]  wr_data = 8'd0;
  logic        wr_ready, rd_valid, out_nak, irq, dma_req, ovf_flag, udf_flag;
  logic [31:0] rd_data;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  iso_out_pingpong u_iso_out_pingpong (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_eop(wr_eop), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .out_nak(out_nak), .irq(irq),
    .dma_req(dma_req), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  // {wv, eop, pop, wdata[8], exp rd_valid, exp rd_data[8], exp nak, exp irq}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {3'b100, 8'd10, 1'b0, 8'd0,  1'b0, 1'b0},
    {3'b100, 8'd11, 1'b0, 8'd0,  1'b0, 1'b0},
    {3'b110, 8'd12, 1'b1, 8'd10, 1'b0, 1'b1},
    {3'b100, 8'd20, 1'b1, 8'd10, 1'b0, 1'b1},
    {3'b110, 8'd21, 1'b1, 8'd10, 1'b1, 1'b1},
    {3'b101, 8'd99, 1'b1, 8'd11, 1'b1, 1'b1},
    {3'b001, 8'd0,  1'b1, 8'd12, 1'b1, 1'b1},
    {3'b001, 8'd0,  1'b1, 8'd20, 1'b0, 1'b1},
    {3'b001, 8'd0,  1'b1, 8'd21, 1'b0, 1'b1},
    {3'b001, 8'd0,  1'b0, 8'd21, 1'b0, 1'b0},
    {3'b110, 8'd30, 1'b1, 8'd30, 1'b0, 1'b1},
    {3'b001, 8'd0,  1'b0, 8'd30, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic wv, input logic eop, input logic pop, input logic [7:0] d);
    wr_valid = wv; wr_eop = eop; rd_ready = pop; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_eop = 1'b0; rd_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 rd_data", rd_data, 32'd0);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 irq/dma/nak", {29'd0, irq, dma_req, out_nak}, 32'd0);
    check("R1 flags", {30'd0, ovf_flag, udf_flag}, 32'd0);
    check("R1 wr_ready", {31'd0, wr_ready}, 32'd1);

    // R2 R3 R4 R5 R6 R7: two packets, NAK while both slots full, ordered drain
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18:11]);
      check($sformatf("R2/R4/R5 rd_valid vec%0d", i), {31'd0, rd_valid}, {31'd0, VEC[i][10]});
      check($sformatf("R4/R5 rd_data vec%0d", i), rd_data, {24'd0, VEC[i][9:2]});
      check($sformatf("R6/R7 out_nak vec%0d", i), {31'd0, out_nak}, {31'd0, VEC[i][1]});
      check($sformatf("R6 wr_ready vec%0d", i), {31'd0, wr_ready}, {31'd0, ~VEC[i][1]});
      check($sformatf("R3 irq vec%0d", i), {31'd0, irq}, {31'd0, VEC[i][0]});
      check($sformatf("R3 dma_req vec%0d", i), {31'd0, dma_req}, {31'd0, VEC[i][0]});
    end

    // R9: pop on empty keeps the last byte and sets the sticky flag
    check("R9 udf before", {31'd0, udf_flag}, 32'd0);
    step(1'b0, 1'b0, 1'b1, 8'd0);
    check("R9 udf set", {31'd0, udf_flag}, 32'd1);
    check("R9 rd_data held", rd_data, 32'd30);
    step(1'b0, 1'b0, 1'b0, 8'd0);
    check("R9 udf sticky", {31'd0, udf_flag}, 32'd1);

    // R2: end-of-packet with no bytes closes nothing
    step(1'b0, 1'b1, 1'b0, 8'd0);
    check("R2 empty eop rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R2 empty eop irq", {31'd0, irq}, 32'd0);

    // R8: 130 bytes offered, only first 128 kept
    for (int i = 0; i < 130; i++) step(1'b1, (i == 129), 1'b0, 8'(i + 3));
    check("R8 ovf set", {31'd0, ovf_flag}, 32'd1);
    check("R8 packet closed", {31'd0, rd_valid}, 32'd1);
    for (int i = 0; i < 128; i++) begin
      if (rd_data !== {24'd0, 8'(i + 3)})
        check($sformatf("R8 byte %0d", i), rd_data, {24'd0, 8'(i + 3)});
      step(1'b0, 1'b0, 1'b1, 8'd0);
    end
    checks++;
    check("R8 drained after 128", {31'd0, rd_valid}, 32'd0);
    check("R8 last byte held", rd_data, 32'd130);
    check("R8 ovf sticky", {31'd0, ovf_flag}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule